// File: doc/BRIEF.md
# Pushbutton and Power-Fail Reset Generator

This block controls an open-drain, active-low system reset line that a pushbutton can also pull low. It watches the line level, and when the button pulls the line down it holds the line low itself for a debounce window. It then lets go, checks whether the button is still held, waits for the release, and drives a reset pulse of fixed length. A supply power-fail flag forces the line low for as long as it is set. When the flag clears, a recovery pulse stretches the reset, unless the oscillator was stopped at that moment.

The block gives a pull-low enable to an external pad driver, and a two-bit code that gives the reason the line is being held. When the main supply is absent, the block holds the line low and ignores the button. The debounce, button-pulse and recovery lengths are parameters counted in clock cycles.

Top module: `pbrst_gen`

## Requirements
- R1: The sampled line passes through two synchronizing flops. In the idle state, a falling edge on the synchronized level drives `pull_low` high for exactly `DEB_CYCLES` consecutive cycles, and `cause` = 1 (button).
- R2: If the line reads high a few cycles after the debounce window ends, the block returns to idle (`cause` = 0) and issues no reset pulse.
- R3: If the line is still low after the debounce window, the block leaves `pull_low` low and waits with `cause` = 1 for the line to go high.
- R4: When the button is released after R3, `pull_low` is high for exactly `PB_CYCLES` consecutive cycles, and the block then returns to idle.
- R5: Line edges that the block causes itself do not start a new debounce. No further pulse follows a completed button reset.
- R6: With the supply present, `pwr_fail` = 1 sets `pull_low` and `cause` = 2 (power) from the next cycle. It also aborts any button phase, so no button pulse follows.
- R7: If `osc_run` = 1 when `pwr_fail` clears, `pull_low` stays high for exactly `REC_CYCLES` cycles, starting with the cycle after the clearing edge, with `cause` = 2.
- R8: If `osc_run` = 0 when `pwr_fail` clears, `pull_low` is low and `cause` = 0 from the next cycle.
- R9: While `vmain_ok` = 0, `pull_low` = 1 and `cause` = 3 (no supply), and button edges are ignored. When the supply returns, the R7 or R8 rule applies.
- R10: After reset, `pull_low` = 0 and `cause` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | 1 | Sampled level of the shared reset line |
| pwr_fail | input | 1 | Supply below the power-fail threshold |
| vmain_ok | input | 1 | Main supply present |
| osc_run | input | 1 | Oscillator running |
| pull_low | output | 1 | Enable for the open-drain pull-down |
| cause | output | 2 | 0 none, 1 button, 2 power, 3 no supply |

## Verification
The hardest case to reach is a power fail that cuts into a button sequence while the button is still held. Once the fail clears, no button pulse may follow. The bench models the wired line as low when either the button or the block pulls it. It presses the button, waits for the block's debounce drive to start, and raises `pwr_fail` inside that window. It releases the button while the fail is still set, then clears the fail with the oscillator stopped, and watches the line for any later pulse.

// File: rtl/pbrst_gen.sv
module pbrst_gen #(
  parameter int DEB_CYCLES = 20000,
  parameter int PB_CYCLES  = 50000,
  parameter int REC_CYCLES = 250000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_in,
  input  logic       pwr_fail,
  input  logic       vmain_ok,
  input  logic       osc_run,
  output logic       pull_low,
  output logic [1:0] cause
);
  localparam int SETTLE = 3;
  localparam int MAXC   = (DEB_CYCLES > PB_CYCLES) ?
                          ((DEB_CYCLES > REC_CYCLES) ? DEB_CYCLES : REC_CYCLES) :
                          ((PB_CYCLES > REC_CYCLES) ? PB_CYCLES : REC_CYCLES);
  localparam int CW     = $clog2(MAXC + SETTLE + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_DEB, S_SMP, S_WREL, S_PBP, S_PFH, S_REC, S_NOSUP
  } st_t;

  st_t st, nxt;
  logic [CW-1:0] cnt;
  logic s1, s2, s3;
  logic fall, timed, done;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {s1, s2, s3} <= 3'b111;
    else        {s1, s2, s3} <= {line_in, s1, s2};

  assign fall  = s3 & ~s2;
  assign timed = (st == S_DEB) || (st == S_SMP) || (st == S_PBP) || (st == S_REC);

  always_comb begin
    case (st)
      S_DEB:   done = (cnt == CW'(DEB_CYCLES - 1));
      S_SMP:   done = (cnt == CW'(SETTLE - 1));
      S_PBP:   done = (cnt == CW'(PB_CYCLES - 1));
      S_REC:   done = (cnt == CW'(REC_CYCLES - 1));
      default: done = 1'b0;
    endcase
  end

  always_comb begin
    nxt = st;
    if (!vmain_ok)     nxt = S_NOSUP;
    else if (pwr_fail) nxt = S_PFH;
    else begin
      case (st)
        S_IDLE:  if (fall) nxt = S_DEB;
        S_DEB:   if (done) nxt = S_SMP;
        S_SMP:   if (done) nxt = s2 ? S_IDLE : S_WREL;
        S_WREL:  if (s2)   nxt = S_PBP;
        S_PBP:   if (done) nxt = S_IDLE;
        S_REC:   if (done) nxt = S_IDLE;
        S_PFH, S_NOSUP: nxt = osc_run ? S_REC : S_IDLE;
        default: nxt = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st  <= S_IDLE;
      cnt <= '0;
    end else begin
      st  <= nxt;
      cnt <= (nxt != st) ? '0 : (timed ? cnt + 1'b1 : cnt);
    end

  assign pull_low = (st == S_DEB) || (st == S_PBP) || (st == S_PFH) ||
                    (st == S_REC) || (st == S_NOSUP);

  always_comb begin
    case (st)
      S_DEB, S_SMP, S_WREL, S_PBP: cause = 2'd1;
      S_PFH, S_REC:                cause = 2'd2;
      S_NOSUP:                     cause = 2'd3;
      default:                     cause = 2'd0;
    endcase
  end
endmodule

module pbrst_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pwr_fail,
  input logic       vmain_ok,
  input logic       pull_low,
  input logic [1:0] cause
);
  // R9
  nosup_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vmain_ok |=> (pull_low && cause == 2'd3));
  // R6
  pfail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vmain_ok && pwr_fail) |=> (pull_low && cause == 2'd2));
  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cause == 2'd0) |-> !pull_low);
  // R7
  power_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cause == 2'd2) |-> pull_low);
  // R6
  no_button_after_pf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vmain_ok && pwr_fail) |=> (cause != 2'd1));
endmodule

bind pbrst_gen pbrst_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_fail(pwr_fail), .vmain_ok(vmain_ok),
  .pull_low(pull_low), .cause(cause)
);

// File: tb/pbrst_gen_tb.sv
module pbrst_gen_tb;
  localparam int DEB = 8;
  localparam int PB  = 12;
  localparam int REC = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic btn = 1'b0, pf = 1'b0, vok = 1'b1, osc = 1'b1;
  logic pull_low;
  logic [1:0] cause;
  logic line;
  int checks = 0, fails = 0;
  bit finished = 1'b0;

  assign line = !(pull_low || btn);

  always #5 clk = ~clk;

  pbrst_gen #(.DEB_CYCLES(DEB), .PB_CYCLES(PB), .REC_CYCLES(REC)) u_dut (
    .clk(clk), .rst_n(rst_n), .line_in(line), .pwr_fail(pf),
    .vmain_ok(vok), .osc_run(osc), .pull_low(pull_low), .cause(cause)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_rise(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (pull_low) begin seen = 1'b1; break; end
    end
  endtask

  task automatic count_run(output int n);
    n = 0;
    while (pull_low && n < 1000) begin n++; @(negedge clk); end
  endtask

  task automatic watch_quiet(input int cyc, output int hits);
    hits = 0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      if (pull_low) hits++;
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(!pull_low && cause == 2'd0, "R10", {pull_low, cause}, 0);
  endtask

  task automatic t_long_press;
    bit seen; int n, hits;
    btn = 1'b1;
    wait_rise(seen);
    check(seen && cause == 2'd1, "R1 start", cause, 1);
    count_run(n);
    check(n == DEB, "R1 debounce length", n, DEB);
    repeat (10) @(negedge clk);
    check(!pull_low && cause == 2'd1, "R3 waiting", {pull_low, cause}, 1);
    btn = 1'b0;
    wait_rise(seen);
    check(seen, "R4 pulse start", seen, 1);
    count_run(n);
    check(n == PB, "R4 pulse length", n, PB);
    watch_quiet(50, hits);
    check(hits == 0, "R5 no retrigger", hits, 0);
    check(cause == 2'd0, "R4 back idle", cause, 0);
  endtask

  task automatic t_short_press;
    bit seen; int n, hits;
    btn = 1'b1;
    wait_rise(seen);
    repeat (3) @(negedge clk);
    btn = 1'b0;
    count_run(n);
    check(n == DEB - 3, "R1 short debounce", n, DEB - 3);
    watch_quiet(40, hits);
    check(hits == 0, "R2 no pulse", hits, 0);
    check(cause == 2'd0, "R2 idle", cause, 0);
  endtask

  task automatic t_power;
    int n;
    osc = 1'b1;
    pf = 1'b1;
    @(negedge clk);
    check(pull_low && cause == 2'd2, "R6 hold", {pull_low, cause}, 6);
    repeat (5) @(negedge clk);
    pf = 1'b0;
    @(negedge clk);
    count_run(n);
    check(n == REC, "R7 recovery length", n, REC);
    check(cause == 2'd0, "R7 idle after", cause, 0);
    osc = 1'b0;
    pf = 1'b1;
    repeat (3) @(negedge clk);
    pf = 1'b0;
    @(negedge clk);
    check(!pull_low && cause == 2'd0, "R8 bypass", {pull_low, cause}, 0);
    osc = 1'b1;
  endtask

  task automatic t_abort;
    bit seen; int hits;
    btn = 1'b1;
    wait_rise(seen);
    repeat (2) @(negedge clk);
    pf = 1'b1;
    @(negedge clk);
    check(cause == 2'd2, "R6 abort", cause, 2);
    btn = 1'b0;
    repeat (5) @(negedge clk);
    osc = 1'b0;
    pf = 1'b0;
    watch_quiet(40, hits);
    check(hits == 0, "R6 no button pulse", hits, 0);
    osc = 1'b1;
  endtask

  task automatic t_nosupply;
    int n, hits;
    vok = 1'b0;
    @(negedge clk);
    check(pull_low && cause == 2'd3, "R9 no supply", {pull_low, cause}, 7);
    btn = 1'b1;
    repeat (5) @(negedge clk);
    btn = 1'b0;
    repeat (5) @(negedge clk);
    check(cause == 2'd3, "R9 still", cause, 3);
    osc = 1'b0;
    vok = 1'b1;
    watch_quiet(40, hits);
    check(hits == 0, "R9 edges ignored", hits, 0);
    vok = 1'b0;
    osc = 1'b1;
    repeat (3) @(negedge clk);
    vok = 1'b1;
    @(negedge clk);
    count_run(n);
    check(n == REC, "R9 recovery", n, REC);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_long_press();
    t_short_press();
    t_power();
    t_abort();
    t_nosupply();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule